// File: doc/BRIEF.md
# Timer Overflow Flag and Capture/Compare Role Control

This block is an up-counting timer with two channel registers. Each channel works either as a compare register, which pulses a match output when the count reaches its value, or as a capture register, which stores the count when its trigger input rises. An 8-bit option register on a byte-wide write port with a combinational read port holds two role-select bits and a sticky overflow flag. A run-enable input starts the count. While it is low the count is held at zero.

The overflow flag and its interrupt pulse work only in free-running mode and pulse-width-measurement mode. Software can clear the flag but cannot set it. The role-select bits are locked while the timer runs. Only in free-running mode do they turn a channel into a capture register. In every other mode both channels compare.

Top module: `tmr16_capcmp`

## Requirements
- R1: After reset, busRdData reads 0x00, count is 0, both channel registers are 0, and cmpMatch and ovfIrq are low.
- R2: In the option register, bit 0 is the overflow flag, bit 4 is the role select for channel 0 and bit 5 is the role select for channel 1. Bits 1, 2, 3, 6 and 7 always read 0, whatever value is written.
- R3: While runEn is 1, count increases by one on each clock and wraps modulo 2^CNT_W. While runEn is 0, count is 0 one clock later.
- R4: Mode 0 (free-running) and mode 1 (pulse-width measurement) are the flag modes. In a flag mode, a clock edge that moves a running count from all-ones to zero sets the flag. ovfIrq is high for exactly the one cycle in which the flag first reads 1.
- R5: In mode 2 and mode 3 a wrap leaves the flag unchanged and does not raise ovfIrq.
- R6: An accepted write with bit 0 = 0 clears the flag. Writing 1 to bit 0 never sets the flag. Leaving the register on the read port does not clear the flag.
- R7: While runEn is 0, the flag is 0 one clock later.
- R8: When an overflow and an accepted clearing write fall on the same clock edge, the flag ends up set.
- R9: While runEn is 1, a write whose bits 5:4 differ from the stored role selects is ignored as a whole, flag clear included. A write with matching bits 5:4 is accepted. While runEn is 0, every write is accepted.
- R10: A channel is in the compare role when its select bit is 0 or the mode is not 0. In that role, chWrEn[i] loads chWrData into the channel at the clock edge. cmpMatch[i] is high while runEn is 1 and count equals the channel value.
- R11: A channel is in the capture role when its select bit is 1 and the mode is 0. In that role, a clock edge at which capTrig[i] is 1 (and was 0 at the previous edge) while running stores the current count in the channel. In the capture role, cmpMatch[i] stays low and chWrEn[i] has no effect.
- R12: A channel in the capture role reads 0 one clock after runEn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Count enable |
| mode | input | 2 | Timer mode: 0 free-running, 1 pulse-width measurement, 2 and 3 other modes |
| busWrEn | input | 1 | Option register write strobe |
| busWrData | input | 8 | Option register write data |
| busRdData | output | 8 | Option register read data |
| chWrEn | input | 2 | Per-channel compare value load strobe |
| chWrData | input | CNT_W | Compare value to load |
| capTrig | input | 2 | Per-channel capture trigger |
| count | output | CNT_W | Current counter value |
| chRegs | output | 2*CNT_W | Channel values, channel 0 in the low bits |
| cmpMatch | output | 2 | Per-channel compare match |
| ovfIrq | output | 1 | Overflow interrupt pulse |

## Verification
The assertions check, on every cycle, that the count steps by one or is held at zero, and that the flag only rises on a wrap in a flag mode. They also check that ovfIrq never appears outside the flag modes, that stopping clears the flag and empties the capture channels, and that the role selects never move while running. Only the bench scenarios can show the following: the exact wrap cycle, that the flag wins over a clearing write on that same edge, that a rejected write also drops its flag clear, the position of each compare pulse over a full period, and the captured value for triggers placed at several counts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CH_N     = 2;
  localparam int FLAG_BIT = 0;
  localparam int SEL_LSB  = 4;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_PULSE = 2'd1,
    MODE_OTH_A = 2'd2,
    MODE_OTH_B = 2'd3
  } tmrMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic            run;
    logic [CH_N-1:0] capMode;
  } ctlStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       runEn,
  input  logic [1:0] mode,
  input  logic       busWrEn,
  input  logic [7:0] busWrData,
  input  logic       wrapEvt,
  output logic [7:0] busRdData,
  output logic       ovfIrq,
  output ctlStrobe_t strobe
);
  tmrMode_e        modeE;
  logic            modeOk;
  logic            wrAccept;
  logic            flagQ;
  logic [CH_N-1:0] selQ;
  logic            setOvf;

  assign modeE    = tmrMode_e'(mode);
  assign modeOk   = (modeE == MODE_FREE) || (modeE == MODE_PULSE);
  assign wrAccept = busWrEn &&
                    (!runEn || (busWrData[SEL_LSB +: CH_N] == selQ));
  assign setOvf   = wrapEvt && modeOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= 1'b0;
      selQ   <= '0;
      ovfIrq <= 1'b0;
    end else begin
      ovfIrq <= setOvf;
      if (setOvf)
        flagQ <= 1'b1;
      else if (!runEn)
        flagQ <= 1'b0;
      else if (wrAccept && !busWrData[FLAG_BIT])
        flagQ <= 1'b0;
      if (wrAccept)
        selQ <= busWrData[SEL_LSB +: CH_N];
    end
  end

  always_comb begin
    busRdData                   = '0;
    busRdData[FLAG_BIT]         = flagQ;
    busRdData[SEL_LSB +: CH_N]  = selQ;
  end

  always_comb begin
    strobe.run = runEn;
    for (int i = 0; i < CH_N; i++)
      strobe.capMode[i] = selQ[i] && (modeE == MODE_FREE);
  end

  // R4
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ) |-> $past(wrapEvt && modeOk));

  // R5
  irq_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfIrq |-> ($past(modeOk) && flagQ));

  // R7
  flag_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !flagQ);

  // R9
  sel_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    runEn |=> $stable(selQ));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobe_t            strobe,
  input  logic [CH_N-1:0]       chWrEn,
  input  logic [CNT_W-1:0]      chWrData,
  input  logic [CH_N-1:0]       capTrig,
  output logic [CNT_W-1:0]      count,
  output logic [CH_N*CNT_W-1:0] chRegs,
  output logic [CH_N-1:0]       cmpMatch,
  output logic                  wrapEvt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CH_N-1:0] trigPrev;

  assign wrapEvt = strobe.run && (count == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      count <= '0;
    else if (strobe.run)
      count <= count + 1'b1;
    else
      count <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) trigPrev <= '0;
    else       trigPrev <= capTrig;
  end

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    logic [CNT_W-1:0] chQ;
    logic             trigRise;

    assign trigRise = capTrig[g] && !trigPrev[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        chQ <= '0;
      else if (strobe.capMode[g]) begin
        if (!strobe.run)
          chQ <= '0;
        else if (trigRise)
          chQ <= count;
      end else if (chWrEn[g])
        chQ <= chWrData;
    end

    assign chRegs[g*CNT_W +: CNT_W] = chQ;
    assign cmpMatch[g] = strobe.run && !strobe.capMode[g] && (count == chQ);

    // R12
    cap_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strobe.run && strobe.capMode[g]) |=> (chQ == '0));
  end

  // R3
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |=> (count == '0));

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.run |=> (count == CNT_W'($past(count) + 1'b1)));
endmodule

// File: rtl/tmr16_capcmp.sv
module tmr16_capcmp
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  runEn,
  input  logic [1:0]            mode,
  input  logic                  busWrEn,
  input  logic [7:0]            busWrData,
  output logic [7:0]            busRdData,
  input  logic [CH_N-1:0]       chWrEn,
  input  logic [CNT_W-1:0]      chWrData,
  input  logic [CH_N-1:0]       capTrig,
  output logic [CNT_W-1:0]      count,
  output logic [CH_N*CNT_W-1:0] chRegs,
  output logic [CH_N-1:0]       cmpMatch,
  output logic                  ovfIrq
);
  ctlStrobe_t strobe;
  logic       wrapEvt;

  tmr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .mode      (mode),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .wrapEvt   (wrapEvt),
    .busRdData (busRdData),
    .ovfIrq    (ovfIrq),
    .strobe    (strobe)
  );

  tmr_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .chWrEn   (chWrEn),
    .chWrData (chWrData),
    .capTrig  (capTrig),
    .count    (count),
    .chRegs   (chRegs),
    .cmpMatch (cmpMatch),
    .wrapEvt  (wrapEvt)
  );
endmodule

// File: tb/tmr16_capcmp_bench.sv
module tmr16_capcmp_bench;
  localparam int W = 8;
  localparam int PERIOD = 1 << W;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         runEn = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         busWrEn = 1'b0;
  logic [7:0]   busWrData = 8'h00;
  logic [7:0]   busRdData;
  logic [1:0]   chWrEn = 2'b00;
  logic [W-1:0] chWrData = '0;
  logic [1:0]   capTrig = 2'b00;
  logic [W-1:0] count;
  logic [2*W-1:0] chRegs;
  logic [1:0]   cmpMatch;
  logic         ovfIrq;

  int nRun = 0;
  int nFail = 0;

  always #5 clk = ~clk;

  tmr16_capcmp #(.CNT_W(W)) u_tmr16_capcmp (
    .clk(clk), .rstN(rstN), .runEn(runEn), .mode(mode),
    .busWrEn(busWrEn), .busWrData(busWrData), .busRdData(busRdData),
    .chWrEn(chWrEn), .chWrData(chWrData), .capTrig(capTrig),
    .count(count), .chRegs(chRegs), .cmpMatch(cmpMatch), .ovfIrq(ovfIrq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wrOpt(input logic [7:0] d);
    busWrData = d; busWrEn = 1'b1;
    tick();
    busWrEn = 1'b0;
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int ch, c, v0, v1, m;
    repeat (3) tick();
    rstN = 1'b1;
    tick(); #1;
    // R1 reset state
    check(busRdData == 8'h00, "R1 opt", busRdData, 0);
    check(count == 0, "R1 count", count, 0);
    check(chRegs == 0, "R1 chRegs", chRegs, 0);
    check(cmpMatch == 0 && !ovfIrq, "R1 outs", {cmpMatch, ovfIrq}, 0);

    // R2 reserved bits read 0, select positions; R6 flag not settable
    wrOpt(8'hFF);
    check(busRdData == 8'h30, "R2 R6 write ff", busRdData, 8'h30);
    wrOpt(8'h10);
    check(busRdData == 8'h10, "R2 sel0", busRdData, 8'h10);
    wrOpt(8'h20);
    check(busRdData == 8'h20, "R2 sel1", busRdData, 8'h20);
    wrOpt(8'h00);

    // R3 R4 counting and first wrap in free-running mode
    runEn = 1'b1;
    for (int k = 1; k <= 300; k++) begin
      tick(); #1;
      check(count == (k % PERIOD), "R3 count", count, k % PERIOD);
      check(ovfIrq == (k == PERIOD), "R4 irq", ovfIrq, k == PERIOD);
      check(busRdData[0] == (k >= PERIOD), "R4 R6 flag", busRdData[0], k >= PERIOD);
    end

    // R6 writing 1 keeps flag, writing 0 clears
    wrOpt(8'h01);
    check(busRdData == 8'h01, "R6 write1", busRdData, 1);
    wrOpt(8'h00);
    check(busRdData == 8'h00, "R6 clear", busRdData, 0);

    // R8 overflow beats clear on same edge
    while (count != W'(PERIOD - 1)) tick();
    wrOpt(8'h00);
    check(busRdData[0] == 1'b1, "R8 flag", busRdData[0], 1);
    check(ovfIrq == 1'b1, "R8 irq", ovfIrq, 1);

    // R9 select change while running ignored, flag clear dropped too
    wrOpt(8'h10);
    check(busRdData == 8'h01, "R9 locked", busRdData, 1);

    // R7 stop clears flag, R3 count held at 0
    runEn = 1'b0;
    tick(); #1;
    check(busRdData == 8'h00, "R7 flag", busRdData, 0);
    check(count == 0, "R3 idle", count, 0);
    wrOpt(8'h30);
    check(busRdData == 8'h30, "R9 idle write", busRdData, 8'h30);
    wrOpt(8'h00);

    // R4 R5 mode sweep
    for (m = 0; m < 4; m++) begin
      mode = 2'(m);
      runEn = 1'b1;
      repeat (PERIOD) tick();
      #1;
      check(busRdData[0] == (m < 2), "R4 R5 flag by mode", busRdData[0], m < 2);
      check(ovfIrq == (m < 2), "R4 R5 irq by mode", ovfIrq, m < 2);
      tick(); #1;
      check(ovfIrq == 1'b0, "R4 one-cycle irq", ovfIrq, 0);
      runEn = 1'b0;
      tick();
    end

    // R10 compare sweep; last pair in mode 2 with selects set (still compare)
    for (int p = 0; p < 5; p++) begin
      case (p)
        0: begin v0 = 0;   v1 = 255; end
        1: begin v0 = 17;  v1 = 17;  end
        2: begin v0 = 128; v1 = 3;   end
        3: begin v0 = 200; v1 = 201; end
        default: begin v0 = 9; v1 = 250; end
      endcase
      runEn = 1'b0;
      mode = (p == 4) ? 2'd2 : 2'd0;
      wrOpt((p == 4) ? 8'h30 : 8'h00);
      chWrEn = 2'b01; chWrData = W'(v0); tick();
      chWrEn = 2'b10; chWrData = W'(v1); tick();
      chWrEn = 2'b00; #1;
      check(chRegs == {W'(v1), W'(v0)}, "R10 load", chRegs, {W'(v1), W'(v0)});
      runEn = 1'b1; #1;
      for (int k = 0; k < PERIOD; k++) begin
        check(count == W'(k), "R3 compare count", count, k);
        check(cmpMatch[0] == (k == v0), "R10 match0", cmpMatch[0], k == v0);
        check(cmpMatch[1] == (k == v1), "R10 match1", cmpMatch[1], k == v1);
        tick(); #1;
      end
    end

    // R11 capture sweep in free-running mode
    runEn = 1'b0; mode = 2'd0;
    tick();
    wrOpt(8'h30);
    runEn = 1'b1;
    for (int q = 0; q < 4; q++) begin
      ch = q % 2;
      c = (q == 0) ? 5 : (q == 1) ? 77 : (q == 2) ? 200 : 254;
      while (count != W'(c)) tick();
      capTrig[ch] = 1'b1;
      tick(); #1;
      check(chRegs[ch*W +: W] == W'(c), "R11 capture", chRegs[ch*W +: W], c);
      tick(); #1;
      check(chRegs[ch*W +: W] == W'(c), "R11 held trigger", chRegs[ch*W +: W], c);
      capTrig[ch] = 1'b0;
    end
    chWrEn = 2'b11; chWrData = 8'hAA;
    tick(); chWrEn = 2'b00; #1;
    check(chRegs == {8'd254, 8'd200}, "R11 write ignored", chRegs, {8'd254, 8'd200});
    for (int k = 0; k < PERIOD; k++) begin
      check(cmpMatch == 2'b00, "R11 no match", cmpMatch, 0);
      tick(); #1;
    end

    // R12 capture channels emptied on stop
    runEn = 1'b0;
    tick(); #1;
    check(chRegs == 0, "R12 cleared", chRegs, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule